// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits (32 by default) over a run of clock cycles. It gives a signed product of `2*WIDTH` bits. A single `WIDTH`-bit adder/subtractor does all the arithmetic. The product register is `2*WIDTH` bits wide, and its lower half starts out holding the multiplier. On every iteration the block looks at the lowest bit of that register together with the bit shifted out on the previous iteration. From these two bits it chooses one action on the upper half: add the multiplicand, subtract it, or leave the upper half unchanged. It then shifts the whole register one place right, keeping the sign.

A caller pulses `start` with both operands while the block is idle. `busy` then stays high for exactly `WIDTH` iterations. `done` pulses for one cycle as `busy` falls, and at that point `product` holds the result. The result stays on `product` until the next accepted start. A start request that arrives while the block is busy is dropped.

Top module: `booth_seq_mul`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled while `busy` is 0 captures both operands. On the next cycle `busy` is 1 and `product` equals the multiplier zero-extended to `2*WIDTH` bits.
- R3: Once set by a start, `busy` stays high for exactly `WIDTH` cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R4: In the cycle `done` is high, `product` equals the signed product of the captured multiplicand and multiplier, using two's-complement interpretation.
- R5: A `start` sampled while `busy` is 1 is ignored. The operands are not re-captured, the iteration count is not restarted, and the result matches the first request.
- R6: The recoding uses the pair (current multiplier bit, bit to its right), where the bit to the right of the least significant bit is taken as 0. The pair 10 subtracts the multiplicand, 01 adds it, and 00 and 11 leave the upper half unchanged before the shift.
- R7: The right shift is arithmetic, and the partial sum carries one extra sign bit. As a result the extreme operands give exact products: the most negative value squared gives 2^(2*WIDTH-2).
- R8: While idle with no start, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication (taken only while idle) |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Product register, signed result after done |

## Verification
The assertions assume that `start` is a clean synchronous level, sampled only on rising edges, and that the operands are stable in any cycle where `start` is high. No assumption is made about `start` being low while busy. The bench drives on falling edges, so every input is settled at the sampling edge. It deliberately raises `start` in the middle of a run with different operands, to exercise the ignore path. It also raises `start` in the same cycle as `done`, to exercise back-to-back operation.

// File: rtl/booth_pkg.sv
// Package: types shared by the Booth multiplier modules.
// Assumes: nothing; pure type definitions.
package booth_pkg;
    typedef enum logic [1:0] {
        ACT_NOP = 2'd0,
        ACT_ADD = 2'd1,
        ACT_SUB = 2'd2
    } booth_act_e;
endpackage

// File: rtl/booth_recode.sv
// Module: booth_recode
// Turns the (current bit, previous bit) pair into an add/subtract/skip action.
// Assumes: prev_bit is the multiplier bit shifted out on the previous step (0 first).
module booth_recode
    import booth_pkg::*;
(
    input  logic       cur_bit,
    input  logic       prev_bit,
    output booth_act_e act
);
    // Purpose: radix-2 Booth decode of the bit pair.
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   act = ACT_SUB;
            2'b01:   act = ACT_ADD;
            default: act = ACT_NOP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
// Module: booth_addsub
// One WIDTH-bit adder/subtractor whose result carries an extra sign bit.
// Assumes: both inputs are two's-complement; result is one bit wider.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] operand,
    input  booth_act_e       act,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH:0] acc_x;
    logic [WIDTH:0] opd_x;

    // Purpose: sign-extend both inputs by one bit.
    always_comb begin
        acc_x = {acc[WIDTH-1], acc};
        opd_x = {operand[WIDTH-1], operand};
    end

    // Purpose: apply the selected action.
    always_comb begin
        unique case (act)
            ACT_ADD: sum = acc_x + opd_x;
            ACT_SUB: sum = acc_x - opd_x;
            default: sum = acc_x;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
// Module: booth_ctrl
// Iteration sequencer: accepts start when idle, runs WIDTH steps, pulses done.
// Assumes: start is synchronous; requests while busy are dropped here.
module booth_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last_step;

    // Purpose: derive load/step strobes from the current state.
    always_comb begin
        load      = start & ~busy;
        step      = busy;
        last_step = busy & (cnt_q == LAST_CNT);
    end

    // Purpose: busy flag, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= last_step;
            if (load) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end else if (busy) begin
                if (last_step) begin
                    busy <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R3: counter never passes the last step index.
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);
    // R3: done lasts one cycle.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: done only while idle.
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2: an idle start makes the block busy.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/booth_seq_mul.sv
// Module: booth_seq_mul (top)
// Radix-2 Booth sequential signed multiplier sharing the product register
// with the multiplier. One add/sub plus arithmetic shift per cycle.
// Assumes: operands stable while start is high; start ignored while busy.
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    prod_q;
    logic [WIDTH-1:0] mcand_q;
    logic             prev_q;
    logic             load;
    logic             step;
    booth_act_e       act;
    logic [WIDTH:0]   sum;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    booth_recode u_recode (
        .cur_bit  (prod_q[0]),
        .prev_bit (prev_q),
        .act      (act)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc     (prod_q[PW-1:WIDTH]),
        .operand (mcand_q),
        .act     (act),
        .sum     (sum)
    );

    // Purpose: load operands, then add/sub and arithmetic-shift each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            prev_q  <= 1'b0;
        end else if (load) begin
            prod_q  <= {{WIDTH{1'b0}}, mplier};
            mcand_q <= mcand;
            prev_q  <= 1'b0;
        end else if (step) begin
            prod_q  <= {sum, prod_q[WIDTH-1:1]};
            prev_q  <= prod_q[0];
        end
    end

    assign product = prod_q;

    // R6: a 00/11 pair only shifts the upper half arithmetically.
    p_skip_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (prod_q[0] == prev_q)) |=>
            (prod_q[PW-1:WIDTH-1] == {$past(prod_q[PW-1]), $past(prod_q[PW-1:WIDTH])}));
    // R5: captured multiplicand is untouched during a run.
    p_mcand_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mcand_q));
    // R8: idle without start keeps the product.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
    // R2: product holds the zero-extended multiplier after an accepted start.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (product == {{WIDTH{1'b0}}, $past(mplier)}));
endmodule

// File: tb/tb_booth_seq_mul.sv
`timescale 1ns/1ps
module tb_booth_seq_mul;
    localparam int W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [W-1:0]    mcand = '0;
    logic [W-1:0]    mplier = '0;
    logic            busy;
    logic            done;
    logic [2*W-1:0]  product;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference model state
    bit              m_busy = 0;
    bit              m_done = 0;
    bit              m_loaded = 0;
    int              m_left = 0;
    logic [2*W-1:0]  m_prod = '0;
    logic [2*W-1:0]  m_result = '0;

    always #2 clk = ~clk;

    booth_seq_mul #(.WIDTH(W)) dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .mcand (mcand), .mplier (mplier),
        .busy (busy), .done (done), .product (product)
    );

    // behavioural cycle model built from the requirements
    always @(posedge clk) begin
        m_loaded = 0;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; m_prod = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_prod = m_result;
                end
            end else if (start) begin
                longint sa;
                longint sb;
                sa = longint'($signed(mcand));
                sb = longint'($signed(mplier));
                m_result = 64'(sa * sb);
                m_prod = {{W{1'b0}}, mplier};
                m_busy = 1; m_left = W; m_loaded = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            check(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
            check(done == m_done, "R3 done", 64'(done), 64'(m_done));
            if (!rst_n)
                ;
            else if (m_loaded)
                check(product == m_prod, "R2 load", product, m_prod);
            else if (m_done)
                check(product == m_prod, "R4 result", product, m_prod);
            else if (!m_busy)
                check(product == m_prod, "R8 hold", product, m_prod);
        end
    end

    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < W + 4; i++) begin
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [W-1:0] lcg;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0 && product == '0, "R1 reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 and R6: assorted patterns
        run_mul(32'd3, 32'd5);
        run_mul(-32'sd4, 32'd6);          // R6: recoded +8 -2 gives -24
        run_mul(-32'sd1, -32'sd1);
        run_mul(32'd0, 32'h1234_5678);
        run_mul(32'hAAAA_AAAA, 32'h5555_5555);
        run_mul(32'h5555_5555, 32'hFFFF_0000);
        // R7: extreme operands
        run_mul(32'h8000_0000, 32'h8000_0000);
        run_mul(32'h7FFF_FFFF, 32'h8000_0000);
        run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run_mul(32'h8000_0000, 32'hFFFF_FFFF);
        // R5: start while busy is ignored
        @(negedge clk);
        start = 1'b1; mcand = 32'd1000; mplier = -32'sd7;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; mcand = 32'd99; mplier = 32'd99;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(product == 64'(-64'sd7000), "R5 ignore", product, 64'(-64'sd7000));
        // back-to-back: start in the done cycle
        start = 1'b1; mcand = 32'd12; mplier = -32'sd12;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(product == 64'(-64'sd144), "R4 back-to-back", product, 64'(-64'sd144));
        // R8: long idle hold
        repeat (8) @(negedge clk);
        // pseudo-random operands
        lcg = 32'h1357_9BDF;
        for (int k = 0; k < 12; k++) begin
            logic [W-1:0] a;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run_mul(a, lcg);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule